// File: doc/BRIEF.md
# Mod-3 Channel Hash Solver

This block works backwards through the address hash that spreads a memory group over three (or six) channels. A hardware channel selector forms a mod-3 residue from several address bit pairs and from the two top bits of the port address. When the port address is translated back to a system address, those two top bits are not known. The block takes the partly assembled real address (group ID bits already inserted), the group ID and the group's channel count. It returns the two-bit value that must be placed in the top of the port address so that the forward hash lands on the channel that owns the data.

All arithmetic is done on 3-bit one-hot residue codes, where bit 2 means residue 0, bit 1 means residue 1 and bit 0 means residue 2. A right rotation by n adds n modulo 3. A left rotation by n subtracts n modulo 3. A chain stage folds three address bit pairs into a partial hash. A second stage forms the target hash from the group ID and a low address pair. A search stage then finds how many single left rotations of the target reach the partial hash. The search is unrolled into a fixed set of compare states: SOLVE_AT0, SOLVE_AT1, SOLVE_AT2 and SOLVE_MISS. The block picks the first rotation count whose candidate matches, in the order 0 → 1 → 2, and falls through to SOLVE_MISS only when no candidate matches. The block is purely combinational, so the output follows the inputs with no clock.

Top module: `mod3_msb_solver`

## Requirements
- R1: A 2-bit pair value v is coded one-hot as 0 → 3'b100, 1 → 3'b010, 2 → 3'b001 and 3 → 3'b100, so a pair value of 3 counts as residue 0.
- R2: The partial hash is the residue of addr_i[16:15], right-rotated by the value of addr_i[18:17] and then by the value of addr_i[20:19]. Its residue is (p0 + p1 + p2) mod 3.
- R3: The target hash is the one-hot code of (grp_id_i mod 3), left-rotated by the value of addr_i[8:7]. Its residue is (id − sel) mod 3.
- R4: When chan_cnt_i equals 6, the target hash uses grp_id_i with bit 0 cleared, and it uses only addr_i[8] (bit 7 taken as 0).
- R5: msb_o equals the number of single left rotations of the target hash that reach the partial hash. This is ((id − sel) − (p0 + p1 + p2)) mod 3, and it always lies in 0..2.
- R6: Address bits outside 20:15 and 8:7 have no effect on msb_o.
- R7: Any chan_cnt_i value other than 6 uses the full grp_id_i and both bits of addr_i[8:7].
- R8: The search never ends in SOLVE_MISS, and rotating the target hash left by msb_o always yields the partial hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 64 | Real address after group ID insertion (bit 0 is the least significant) |
| grp_id_i | input | 3 | Group ID of the channel |
| chan_cnt_i | input | 4 | Number of channels in the group, as a plain count |
| msb_o | output | 2 | Recovered top two port-address bits |

## Verification
The bench uses the default parameters: a 64-bit address, a 3-bit group ID, a 4-bit channel count, and hash pairs that start at bit 15 with the selector pair at bit 7. These small fields allow a full sweep of every combination of the three hash pairs, all eight group IDs and all four selector values, once with a clean address and again with pseudo-random noise in every unused address bit. Each sweep runs with a channel count of three, six, one and fifteen. This reaches the six-channel reduction, the residue wrap of pair value 3, and every rotation count.

// File: rtl/mod3_hash_pkg.sv
package mod3_hash_pkg;

    localparam int RESIDUES  = 3;
    localparam int MAX_STEPS = RESIDUES - 1;

    typedef logic [RESIDUES-1:0] b3_t;

    typedef enum logic [1:0] {
        SOLVE_AT0  = 2'd0,
        SOLVE_AT1  = 2'd1,
        SOLVE_AT2  = 2'd2,
        SOLVE_MISS = 2'd3
    } solve_state_e;

    // Pair value to one-hot residue code; value 3 wraps to residue 0.
    function automatic b3_t pair_to_b3(input logic [1:0] v);
        b3_t r;
        unique case (v)
            2'd0:    r = 3'b100;
            2'd1:    r = 3'b010;
            2'd2:    r = 3'b001;
            default: r = 3'b100;
        endcase
        return r;
    endfunction

    function automatic b3_t rot_right1(input b3_t v);
        return {v[0], v[2:1]};
    endfunction

    function automatic b3_t rot_left1(input b3_t v);
        return {v[1:0], v[2]};
    endfunction

    // Rotate right by amt; a count of 3 behaves as 0.
    function automatic b3_t rot_right(input b3_t v, input logic [1:0] amt);
        b3_t r;
        r = v;
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (amt != 2'd3 && i < int'(amt)) r = rot_right1(r);
        end
        return r;
    endfunction

    // Rotate left by amt; a count of 3 behaves as 0.
    function automatic b3_t rot_left(input b3_t v, input logic [1:0] amt);
        b3_t r;
        r = v;
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (amt != 2'd3 && i < int'(amt)) r = rot_left1(r);
        end
        return r;
    endfunction

    // Residue of an unsigned value: bit weights alternate 1, 2 modulo 3.
    function automatic logic [1:0] value_mod3(input logic [7:0] v);
        int s;
        s = 0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) s = s + ((i % 2 == 0) ? 1 : 2);
        end
        return 2'(s % RESIDUES);
    endfunction

endpackage

// File: rtl/mod3_partial_hash.sv
module mod3_partial_hash
    import mod3_hash_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PAIRS    = 3,
    parameter int BASE_BIT = 15
) (
    input  logic [ADDR_W-1:0] addr_i,
    output b3_t               r2_o
);

    localparam int TOP_BIT = BASE_BIT + 2*PAIRS - 1;

    b3_t stage [PAIRS];

    assign stage[0] = pair_to_b3(addr_i[BASE_BIT+1:BASE_BIT]);

    for (genvar p = 1; p < PAIRS; p++) begin : g_chain
        assign stage[p] = rot_right(stage[p-1], addr_i[BASE_BIT+2*p+1:BASE_BIT+2*p]);
    end

    assign r2_o = stage[PAIRS-1];

    always_comb begin
        // R2
        partial_onehot_chk: assert ($countones(r2_o) == 1)
            else $error("partial hash not one-hot: %b", r2_o);
    end

    initial begin
        if (TOP_BIT >= ADDR_W) $error("hash pairs exceed address width");
    end

endmodule

// File: rtl/mod3_target_hash.sv
module mod3_target_hash
    import mod3_hash_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int GID_W     = 3,
    parameter int CNT_W     = 4,
    parameter int SIX_CHAN  = 6,
    parameter int SEL_BIT   = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [GID_W-1:0]  grp_id_i,
    input  logic [CNT_W-1:0]  chan_cnt_i,
    output b3_t               r3_o
);

    localparam logic [CNT_W-1:0] SIX_CODE = CNT_W'(SIX_CHAN);

    logic             six_mode;
    logic [GID_W-1:0] id_eff;
    logic [1:0]       sel_eff;
    logic [1:0]       id_res;
    b3_t              id_code;

    assign six_mode = (chan_cnt_i == SIX_CODE);

    always_comb begin
        id_eff  = grp_id_i;
        sel_eff = addr_i[SEL_BIT+1:SEL_BIT];
        if (six_mode) begin
            id_eff[0]  = 1'b0;
            sel_eff[0] = 1'b0;
        end
    end

    assign id_res  = value_mod3(8'(id_eff));
    assign id_code = pair_to_b3(id_res);
    assign r3_o    = rot_left(id_code, sel_eff);

    always_comb begin
        // R3
        target_onehot_chk: assert ($countones(r3_o) == 1)
            else $error("target hash not one-hot: %b", r3_o);
        // R4
        six_lsb_chk: assert (!six_mode || (id_eff[0] == 1'b0 && sel_eff[0] == 1'b0))
            else $error("six-channel reduction leaked a low bit");
    end

endmodule

// File: rtl/mod3_rot_search.sv
module mod3_rot_search
    import mod3_hash_pkg::*;
(
    input  b3_t        r2_i,
    input  b3_t        r3_i,
    output logic [1:0] msb_o
);

    b3_t          cand [MAX_STEPS+1];
    solve_state_e state;

    assign cand[0] = r3_i;
    for (genvar k = 1; k <= MAX_STEPS; k++) begin : g_cand
        assign cand[k] = rot_left1(cand[k-1]);
    end

    // Choose the first candidate that matches (0, then 1, then 2).
    always_comb begin
        state = SOLVE_MISS;
        for (int k = MAX_STEPS; k >= 0; k--) begin
            if (cand[k] == r2_i) state = solve_state_e'(k);
        end
    end

    // Output decode per state.
    always_comb begin
        unique case (state)
            SOLVE_AT0:  msb_o = 2'd0;
            SOLVE_AT1:  msb_o = 2'd1;
            SOLVE_AT2:  msb_o = 2'd2;
            SOLVE_MISS: msb_o = 2'd0;
            default:    msb_o = 2'd0;
        endcase
    end

    always_comb begin
        // R8
        no_miss_chk: assert (state != SOLVE_MISS)
            else $error("rotation search found no match r2=%b r3=%b", r2_i, r3_i);
        // R5
        msb_range_chk: assert (msb_o <= 2'd2)
            else $error("msb out of range: %0d", msb_o);
    end

endmodule

// File: rtl/mod3_msb_solver.sv
module mod3_msb_solver
    import mod3_hash_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int GID_W     = 3,
    parameter int CNT_W     = 4,
    parameter int SIX_CHAN  = 6,
    parameter int PAIRS     = 3,
    parameter int BASE_BIT  = 15,
    parameter int SEL_BIT   = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [GID_W-1:0]  grp_id_i,
    input  logic [CNT_W-1:0]  chan_cnt_i,
    output logic [1:0]        msb_o
);

    b3_t r2;
    b3_t r3;

    mod3_partial_hash #(
        .ADDR_W   (ADDR_W),
        .PAIRS    (PAIRS),
        .BASE_BIT (BASE_BIT)
    ) partial_i (
        .addr_i (addr_i),
        .r2_o   (r2)
    );

    mod3_target_hash #(
        .ADDR_W   (ADDR_W),
        .GID_W    (GID_W),
        .CNT_W    (CNT_W),
        .SIX_CHAN (SIX_CHAN),
        .SEL_BIT  (SEL_BIT)
    ) target_i (
        .addr_i     (addr_i),
        .grp_id_i   (grp_id_i),
        .chan_cnt_i (chan_cnt_i),
        .r3_o       (r3)
    );

    mod3_rot_search search_i (
        .r2_i  (r2),
        .r3_i  (r3),
        .msb_o (msb_o)
    );

    always_comb begin
        // R8
        solve_close_chk: assert (rot_left(r3, msb_o) == r2)
            else $error("target rotated by %0d misses partial hash", msb_o);
    end

endmodule

// File: tb/mod3_msb_solver_tb_top.sv
module mod3_msb_solver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] addr;
    logic [2:0]  gid;
    logic [3:0]  cnt;
    logic [1:0]  msb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [63:0] lcg = 64'h9E37_79B9_7F4A_7C15;

    localparam logic [63:0] USED_MASK = 64'h0000_0000_001F_8180;

    always #(CLK_PERIOD/2) clk = ~clk;

    mod3_msb_solver dut_i (
        .addr_i     (addr),
        .grp_id_i   (gid),
        .chan_cnt_i (cnt),
        .msb_o      (msb)
    );

    function automatic int model(input logic [63:0] a, input logic [2:0] id, input logic [3:0] c);
        int g, s, p;
        logic [2:0] ide;
        logic [1:0] sel;
        ide = id;
        sel = a[8:7];
        if (c == 4'd6) begin
            ide[0] = 1'b0;
            sel[0] = 1'b0;
        end
        g = int'(ide) % 3;
        s = int'(sel) % 3;
        p = (int'(a[16:15]) % 3) + (int'(a[18:17]) % 3) + (int'(a[20:19]) % 3);
        return (g - s - p + 30) % 3;
    endfunction

    task automatic check(input logic [63:0] a, input logic [2:0] id, input logic [3:0] c,
                         input int exp, input string req);
        @(negedge clk);
        addr = a;
        gid  = id;
        cnt  = c;
        #1;
        n_checks++;
        if (int'(msb) != exp) begin
            n_fail++;
            $display("FAIL %s: addr=%h id=%0d cnt=%0d msb=%0d expected=%0d",
                     req, a, id, c, msb, exp);
        end
    endtask

    task automatic sweep(input logic [3:0] c, input bit noisy);
        for (int p = 0; p < 64; p++) begin
            for (int id = 0; id < 8; id++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [63:0] a;
                    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
                    a = noisy ? (lcg & ~USED_MASK) : 64'd0;
                    a[20:15] = 6'(p);
                    a[8:7]   = 2'(s);
                    // R5 R6 R7: sweep against arithmetic model
                    check(a, 3'(id), c, model(a, 3'(id), c), "R5");
                end
            end
        end
    endtask

    initial begin
        addr = '0;
        gid  = '0;
        cnt  = 4'd3;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset-like idle state: all zero inputs give 0
        check(64'd0, 3'd0, 4'd3, 0, "R5");
        // R1: pair 16:15 alone, id 0
        check(64'h0 | (64'd1 << 15), 3'd0, 4'd3, 2, "R1");
        check(64'h0 | (64'd2 << 15), 3'd0, 4'd3, 1, "R1");
        check(64'h0 | (64'd3 << 15), 3'd0, 4'd3, 0, "R1");
        // R2: upper pairs
        check(64'h0 | (64'd1 << 17), 3'd0, 4'd3, 2, "R2");
        check(64'h0 | (64'd2 << 19), 3'd0, 4'd3, 1, "R2");
        // R3: group ID and selector
        check(64'd0, 3'd4, 4'd3, 1, "R3");
        check(64'h0 | (64'd1 << 7), 3'd0, 4'd3, 2, "R3");
        // R4 vs R7: same inputs, six-channel and three-channel
        check(64'd0, 3'd1, 4'd6, 0, "R4");
        check(64'd0, 3'd1, 4'd3, 1, "R7");
        check(64'h0 | (64'd1 << 7), 3'd0, 4'd6, 0, "R4");
        // R6: every unused bit set
        check(~USED_MASK, 3'd0, 4'd3, 0, "R6");
        check(~USED_MASK | (64'd1 << 15), 3'd0, 4'd1, 2, "R6");

        sweep(4'd3, 1'b0);
        sweep(4'd6, 1'b1);
        sweep(4'd1, 1'b1);
        sweep(4'd15, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule